// File: doc/BRIEF.md
# Outbound Address Window Translator

This block sits between a CPU-side address source and a PCIe transaction generator. It holds a bank of programmable windows. Each window has a 64-bit match value, a 64-bit mask, a 64-bit remap base and a 32-bit action word. Every cycle the block can accept one address. It compares that address against all windows in parallel and returns the result one clock later. If a window hits, the result is the rewritten address and that window's action word. If no window hits, the address comes back unchanged.

Software programs the windows through a 32-bit word write port. Each window has its own 32-byte slot in the write address space. A window starts translating only once the enable bit in its low match word is set, so software writes the other fields first and sets that bit last. A global enable input gates all translation. The transaction generation that uses the action word lies outside this block.

Top module: `outbound_window_xlate`

## Requirements
- R1: After reset every window is disabled and `rsp_valid` and `rsp_hit` are low. A lookup before any programming returns the address unchanged with the hit flag low.
- R2: The write address selects the window in bits [7:5] and the field in bits [4:2]. Field codes are: 0 low match word, 1 high match word, 2 low remap word, 3 high remap word, 4 low mask word, 5 high mask word, 6 action word. Field code 7 is ignored, and so are write address bits [1:0].
- R3: A window hits when bit 0 of its low match word is 1 and (address & mask) equals (match & mask). For this comparison, bit 0 of the match value is taken as 0.
- R4: On a hit, each bit of the output address comes from the remap base where the mask bit is 1 and from the input address where the mask bit is 0.
- R5: On a hit, `rsp_action` carries the full 32-bit action word of the hitting window. Bits [3:0] are the type (0x0 memory, 0x4 I/O) and the upper bits pass through as attributes. On a miss, `rsp_action` is zero.
- R6: When several windows hit, the lowest-numbered one wins, and `rsp_win` gives its index. On a miss, `rsp_win` is zero.
- R7: When `gbl_en` is low, or no window hits, the output address equals the input address and `rsp_hit` is low.
- R8: A lookup presented with `req_valid` high is answered in the next cycle with `rsp_valid` high. `rsp_valid` is low in the cycle after an idle cycle.
- R9: A window whose fields are all written to zero stays disabled and never hits, even though its all-zero mask would otherwise match every address.
- R10: A register write affects lookups presented from the next cycle on. A lookup presented in the same cycle as the write sees the old configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gbl_en | input | 1 | Global translation enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte address of the written word (window and field) |
| wr_data | input | 32 | Written word |
| req_valid | input | 1 | Lookup request valid |
| req_addr | input | 64 | CPU-side address to translate |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | A window matched |
| rsp_addr | output | 64 | Translated or passed-through address |
| rsp_action | output | 32 | Action word of the hitting window, zero on a miss |
| rsp_win | output | 3 | Index of the hitting window, zero on a miss |

## Verification
The assertions assume that `req_addr` and `gbl_en` hold steady through the clock edge at which they are sampled. They also assume that `rsp_*` values are read only while `rsp_valid` is high, because the data registers hold their value during idle cycles. The stimulus changes all inputs only at the falling clock edge and reads responses only in the cycle after a valid request. Writes use field codes 0 to 7, so the ignored code is exercised as well. The address sweeps cover several bit patterns per window region, include overlapping windows and toggle bit 0, and a reference model in the bench computes each expected result.

// File: rtl/owt_pkg.sv
package owt_pkg;
  localparam int unsigned OWT_WORD_W = 32;
  localparam int unsigned OWT_ADDR_W = 2 * OWT_WORD_W;
  localparam int unsigned OWT_SLOT_BITS = 5;
  localparam int unsigned OWT_FLD_W = 3;

  typedef enum logic [OWT_FLD_W-1:0] {
    FLD_MATCH_LO = 3'd0,
    FLD_MATCH_HI = 3'd1,
    FLD_REMAP_LO = 3'd2,
    FLD_REMAP_HI = 3'd3,
    FLD_MASK_LO  = 3'd4,
    FLD_MASK_HI  = 3'd5,
    FLD_ACTION   = 3'd6,
    FLD_UNUSED   = 3'd7
  } owt_field_e;

  typedef struct packed {
    logic [OWT_ADDR_W-1:0] match;
    logic [OWT_ADDR_W-1:0] mask;
    logic [OWT_ADDR_W-1:0] remap;
    logic [OWT_WORD_W-1:0] action;
  } owt_cfg_t;
endpackage

// File: rtl/owt_window_regs.sv
module owt_window_regs
  import owt_pkg::*;
#(
  parameter int unsigned WIN_IDX = 0,
  parameter int unsigned SEL_W   = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [SEL_W-1:0]      wr_win,
  input  logic [OWT_FLD_W-1:0]  wr_fld,
  input  logic [OWT_WORD_W-1:0] wr_data,
  output owt_cfg_t              cfg
);
  owt_cfg_t cfg_q, cfg_d;
  logic     sel;

  assign sel = wr_en && (wr_win == SEL_W'(WIN_IDX));

  always_comb begin
    cfg_d = cfg_q;
    if (sel) begin
      case (owt_field_e'(wr_fld))
        FLD_MATCH_LO: cfg_d.match[OWT_WORD_W-1:0]          = wr_data;
        FLD_MATCH_HI: cfg_d.match[OWT_ADDR_W-1:OWT_WORD_W] = wr_data;
        FLD_REMAP_LO: cfg_d.remap[OWT_WORD_W-1:0]          = wr_data;
        FLD_REMAP_HI: cfg_d.remap[OWT_ADDR_W-1:OWT_WORD_W] = wr_data;
        FLD_MASK_LO:  cfg_d.mask[OWT_WORD_W-1:0]           = wr_data;
        FLD_MASK_HI:  cfg_d.mask[OWT_ADDR_W-1:OWT_WORD_W]  = wr_data;
        FLD_ACTION:   cfg_d.action                         = wr_data;
        default:      cfg_d = cfg_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (sel) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/owt_window_match.sv
module owt_window_match
  import owt_pkg::*;
(
  input  owt_cfg_t              cfg,
  input  logic [OWT_ADDR_W-1:0] addr,
  output logic                  hit,
  output logic [OWT_ADDR_W-1:0] xlated
);
  logic                  win_on;
  logic [OWT_ADDR_W-1:0] cmp_val;

  always_comb begin
    win_on  = cfg.match[0];
    cmp_val = {cfg.match[OWT_ADDR_W-1:1], 1'b0};
    hit     = win_on && ((addr & cfg.mask) == (cmp_val & cfg.mask));
    xlated  = (cfg.remap & cfg.mask) | (addr & ~cfg.mask);
  end
endmodule

// File: rtl/owt_select.sv
module owt_select
  import owt_pkg::*;
#(
  parameter int unsigned NUM_WIN = 8,
  localparam int unsigned WIN_W  = $clog2(NUM_WIN)
) (
  input  logic [NUM_WIN-1:0]                 hits,
  input  logic [NUM_WIN-1:0][OWT_ADDR_W-1:0] xlated,
  input  logic [NUM_WIN-1:0][OWT_WORD_W-1:0] actions,
  input  logic [OWT_ADDR_W-1:0]              pass_addr,
  output logic                               any_hit,
  output logic [WIN_W-1:0]                   win_idx,
  output logic [OWT_ADDR_W-1:0]              out_addr,
  output logic [OWT_WORD_W-1:0]              out_action
);
  always_comb begin
    any_hit    = 1'b0;
    win_idx    = '0;
    out_addr   = pass_addr;
    out_action = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any_hit    = 1'b1;
        win_idx    = WIN_W'(i);
        out_addr   = xlated[i];
        out_action = actions[i];
      end
    end
  end
endmodule

// File: rtl/outbound_window_xlate.sv
module outbound_window_xlate
  import owt_pkg::*;
#(
  parameter int unsigned NUM_WIN = 8,
  localparam int unsigned WIN_W  = $clog2(NUM_WIN),
  localparam int unsigned REG_AW = WIN_W + OWT_SLOT_BITS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  gbl_en,
  input  logic                  wr_en,
  input  logic [REG_AW-1:0]     wr_addr,
  input  logic [OWT_WORD_W-1:0] wr_data,
  input  logic                  req_valid,
  input  logic [OWT_ADDR_W-1:0] req_addr,
  output logic                  rsp_valid,
  output logic                  rsp_hit,
  output logic [OWT_ADDR_W-1:0] rsp_addr,
  output logic [OWT_WORD_W-1:0] rsp_action,
  output logic [WIN_W-1:0]      rsp_win
);
  logic [WIN_W-1:0]                   wr_win;
  logic [OWT_FLD_W-1:0]               wr_fld;
  owt_cfg_t [NUM_WIN-1:0]             cfgs;
  logic [NUM_WIN-1:0]                 win_hit;
  logic [NUM_WIN-1:0]                 win_hit_g;
  logic [NUM_WIN-1:0][OWT_ADDR_W-1:0] win_xl;
  logic [NUM_WIN-1:0][OWT_WORD_W-1:0] win_act;

  logic                  sel_hit;
  logic [WIN_W-1:0]      sel_idx;
  logic [OWT_ADDR_W-1:0] sel_addr;
  logic [OWT_WORD_W-1:0] sel_act;

  logic                  valid_q, valid_d;
  logic                  hit_q, hit_d;
  logic [OWT_ADDR_W-1:0] addr_q, addr_d;
  logic [OWT_WORD_W-1:0] act_q, act_d;
  logic [WIN_W-1:0]      win_q, win_d;

  assign wr_win = wr_addr[REG_AW-1:OWT_SLOT_BITS];
  assign wr_fld = wr_addr[OWT_SLOT_BITS-1:2];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    owt_window_regs #(.WIN_IDX(w), .SEL_W(WIN_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_win  (wr_win),
      .wr_fld  (wr_fld),
      .wr_data (wr_data),
      .cfg     (cfgs[w])
    );
    owt_window_match u_match (
      .cfg    (cfgs[w]),
      .addr   (req_addr),
      .hit    (win_hit[w]),
      .xlated (win_xl[w])
    );
    assign win_act[w]   = cfgs[w].action;
    assign win_hit_g[w] = win_hit[w] && gbl_en;
  end

  owt_select #(.NUM_WIN(NUM_WIN)) u_sel (
    .hits       (win_hit_g),
    .xlated     (win_xl),
    .actions    (win_act),
    .pass_addr  (req_addr),
    .any_hit    (sel_hit),
    .win_idx    (sel_idx),
    .out_addr   (sel_addr),
    .out_action (sel_act)
  );

  always_comb begin
    valid_d = req_valid;
    hit_d   = req_valid && sel_hit;
    addr_d  = sel_addr;
    act_d   = sel_act;
    win_d   = sel_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      hit_q   <= hit_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      act_q  <= '0;
      win_q  <= '0;
    end else if (req_valid) begin
      addr_q <= addr_d;
      act_q  <= act_d;
      win_q  <= win_d;
    end
  end

  assign rsp_valid  = valid_q;
  assign rsp_hit    = hit_q;
  assign rsp_addr   = addr_q;
  assign rsp_action = act_q;
  assign rsp_win    = win_q;
endmodule

// File: rtl/owt_checker.sv
module owt_checker
  import owt_pkg::*;
#(
  parameter int unsigned NUM_WIN = 8,
  localparam int unsigned WIN_W  = $clog2(NUM_WIN)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  gbl_en,
  input logic                  req_valid,
  input logic [OWT_ADDR_W-1:0] req_addr,
  input logic                  rsp_valid,
  input logic                  rsp_hit,
  input logic [OWT_ADDR_W-1:0] rsp_addr,
  input logic [OWT_WORD_W-1:0] rsp_action,
  input logic [WIN_W-1:0]      rsp_win
);
  // R8
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R8
  idle_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R7
  gbl_off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !gbl_en) |=> (!rsp_hit && rsp_addr == $past(req_addr)));

  // R5
  miss_action_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_action == '0));

  // R6
  miss_win_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_win == '0));

  // R1
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);
endmodule

bind outbound_window_xlate owt_checker #(.NUM_WIN(NUM_WIN)) u_owt_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .gbl_en     (gbl_en),
  .req_valid  (req_valid),
  .req_addr   (req_addr),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_addr   (rsp_addr),
  .rsp_action (rsp_action),
  .rsp_win    (rsp_win)
);

// File: tb/outbound_window_xlate_test.sv
`timescale 1ns/1ps
module outbound_window_xlate_test;
  localparam int NW = 8;

  logic        clk;
  logic        rst_n;
  logic        gbl_en;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data;
  logic        req_valid;
  logic [63:0] req_addr;
  logic        rsp_valid;
  logic        rsp_hit;
  logic [63:0] rsp_addr;
  logic [31:0] rsp_action;
  logic [2:0]  rsp_win;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [63:0] m_match [NW];
  logic [63:0] m_mask  [NW];
  logic [63:0] m_remap [NW];
  logic [31:0] m_act   [NW];

  outbound_window_xlate #(.NUM_WIN(NW)) uut (
    .clk(clk), .rst_n(rst_n), .gbl_en(gbl_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr),
    .rsp_action(rsp_action), .rsp_win(rsp_win)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_write(input int w, input int f, input logic [31:0] d);
    case (f)
      0: m_match[w][31:0]  = d;
      1: m_match[w][63:32] = d;
      2: m_remap[w][31:0]  = d;
      3: m_remap[w][63:32] = d;
      4: m_mask[w][31:0]   = d;
      5: m_mask[w][63:32]  = d;
      6: m_act[w]          = d;
      default: ;
    endcase
  endtask

  task automatic model(input logic [63:0] a, input logic g, output logic h,
                       output logic [63:0] oa, output logic [31:0] ac, output logic [2:0] wi);
    h = 0; oa = a; ac = 0; wi = 0;
    for (int w = NW - 1; w >= 0; w--) begin
      logic [63:0] cmpv;
      cmpv = m_match[w] & ~64'h1;
      if (g && m_match[w][0] && ((a & m_mask[w]) == (cmpv & m_mask[w]))) begin
        h = 1; wi = 3'(w); ac = m_act[w];
        oa = (m_remap[w] & m_mask[w]) | (a & ~m_mask[w]);
      end
    end
  endtask

  // starts and ends at a falling edge
  task automatic reg_write(input int w, input int f, input logic [31:0] d, input logic [1:0] lsb = 2'b00);
    wr_en = 1; wr_addr = {3'(w), 3'(f), lsb}; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    model_write(w, f, d);
  endtask

  task automatic program_win(input int w, input logic [63:0] mt, input logic [63:0] mk,
                             input logic [63:0] rm, input logic [31:0] ac, input string req);
    reg_write(w, 1, mt[63:32]);
    reg_write(w, 4, mk[31:0]);
    reg_write(w, 5, mk[63:32]);
    reg_write(w, 2, rm[31:0]);
    reg_write(w, 3, rm[63:32]);
    reg_write(w, 6, ac);
    reg_write(w, 0, mt[31:0]);
  endtask

  task automatic lookup(input logic [63:0] a, input string req);
    logic        eh;
    logic [63:0] ea;
    logic [31:0] eac;
    logic [2:0]  ew;
    model(a, gbl_en, eh, ea, eac, ew);
    req_valid = 1; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk({req, " valid (R8)"}, 64'(rsp_valid), 64'd1);
    chk({req, " hit"}, 64'(rsp_hit), 64'(eh));
    chk({req, " addr"}, rsp_addr, ea);
    chk({req, " action"}, 64'(rsp_action), 64'(eac));
    chk({req, " win"}, 64'(rsp_win), 64'(ew));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int w = 0; w < NW; w++) begin
      m_match[w] = 0; m_mask[w] = 0; m_remap[w] = 0; m_act[w] = 0;
    end
    rst_n = 0; gbl_en = 1; wr_en = 0; wr_addr = 0; wr_data = 0;
    req_valid = 0; req_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    chk("R1 rsp_hit after reset", 64'(rsp_hit), 64'd0);
    lookup(64'h0000_0000_0000_0000, "R1 unprogrammed");
    lookup(64'hDEAD_BEEF_1234_5678, "R1 unprogrammed");

    // R9 all-zero programming keeps windows disabled
    for (int w = 0; w < NW; w++) program_win(w, 0, 0, 0, 0, "R9");
    lookup(64'h0000_0000_8000_0000, "R9 zero windows");
    lookup(64'h1234_0000_0000_0001, "R9 zero windows");

    // R2 R4 R5 sweep: one region per window
    for (int w = 0; w < NW; w++)
      program_win(w, {32'h0, 32'(w) << 28} | 64'h1, {32'hFFFF_FFFF, 32'hF000_0000},
                  {32'(w + 1), 32'hA000_0000}, (32'(w) << 20) | ((w % 2) ? 32'h4 : 32'h0), "R2");
    for (int hi = 0; hi < 2; hi++)
      for (int k = 0; k < 16; k++)
        lookup({32'(hi), (32'(k) << 28) | 32'h0ABC_DEF0}, "R4 R5 region sweep");

    // R6 overlapping windows: 1 and 5 cover a region already owned by 6
    program_win(6, 64'h0000_0000_6000_0001, {32'hFFFF_FFFF, 32'hF000_0000}, 64'h0, 32'h66, "R6");
    program_win(5, 64'h0000_0000_6000_0001, {32'hFFFF_FFFF, 32'hE000_0000}, 64'h77_0000_0000, 32'h55, "R6");
    program_win(1, 64'h0000_0000_6000_0001, {32'hFFFF_FFFF, 32'hC000_0000}, 64'h11_0000_0000, 32'h4, "R6");
    for (int k = 0; k < 16; k++)
      lookup({32'h0, (32'(k) << 28) | 32'h0000_1234}, "R6 priority sweep");

    // R3 enable bit excluded from comparison
    program_win(0, 64'h0000_0009_0000_1001, 64'hFFFF_FFFF_FFFF_FFFF, 64'h5555_0000_0000_0000, 32'h0030_0004, "R3");
    lookup(64'h0000_0009_0000_1000, "R3 bit0 clear hits");
    lookup(64'h0000_0009_0000_1001, "R3 bit0 set misses");
    lookup(64'h0000_0009_0000_1002, "R3 other bit misses");

    // R2 field code 7 and low address bits ignored
    reg_write(0, 7, 32'hFFFF_FFFF);
    reg_write(0, 6, 32'h0000_00A4, 2'b11);
    lookup(64'h0000_0009_0000_1000, "R2 ignored field");

    // R10 write in the same cycle as lookup sees old configuration
    begin
      logic        eh;
      logic [63:0] ea;
      logic [31:0] eac;
      logic [2:0]  ew;
      model(64'h0000_0009_0000_1000, gbl_en, eh, ea, eac, ew);
      wr_en = 1; wr_addr = {3'd0, 3'd0, 2'b00}; wr_data = 32'h0000_1000;
      req_valid = 1; req_addr = 64'h0000_0009_0000_1000;
      @(negedge clk);
      wr_en = 0; req_valid = 0;
      model_write(0, 0, 32'h0000_1000);
      chk("R10 same-cycle hit uses old config", 64'(rsp_hit), 64'(eh));
      chk("R10 same-cycle addr uses old config", rsp_addr, ea);
    end
    lookup(64'h0000_0009_0000_1000, "R10 after disable");

    // R7 global enable clear
    gbl_en = 0;
    for (int k = 0; k < 16; k++)
      lookup({32'(k % 2), (32'(k) << 28) | 32'h0ABC_DEF0}, "R7 global off");
    gbl_en = 1;
    lookup(64'h0000_0000_3000_0000, "R7 global back on");

    // R8 idle cycle
    @(negedge clk);
    chk("R8 idle valid low", 64'(rsp_valid), 64'd0);
    chk("R8 idle hit low", 64'(rsp_hit), 64'd0);

    finish_run();
  end
endmodule